// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block decodes the command writes aimed at a 16-bit-wide NOR flash. A host write cycle is presented as a one-clock strobe with an address and a data word. The block reads the command code from the low data byte. Single-write commands pick the read mode or clear status. Two-write sequences (program, erase, blank check, lock family, protection register, configuration write) end in a one-clock request to a separate write state machine, which carries the operation code, the address and the data.

A status byte shows ready/busy, the erase-suspended flag and two latched error flags. It is captured into the read output at the start of each read access, so a slow reader always sees a steady value. After a request, the read mode stays on status until the host writes a new command.

Top module: `flash_cmd_if`

## Requirements
- R1: The command code is taken from `wrData[7:0]`. The value of `wrData[15:8]` has no effect on how a first write is decoded.
- R2: A first write of 0xFF, 0x90, 0x70 or 0x98 sets `readMode` to 0 (array), 1 (identifier), 2 (status) or 3 (query). The new mode is visible in the clock after the write strobe.
- R3: A first write of 0x50 clears status bits 5 and 4. It leaves bit 6 and `readMode` unchanged and issues no request.
- R4: 0x20 followed by 0xD0 requests erase (`reqOp`=2). 0x20 followed by 0xD1 requests blank check (`reqOp`=3). In both cases the second write must fall in the same block as the first: the same address bits above bit `BLK_LSB` (15 by default). `reqAddr` is the second write's address.
- R5: 0x40 or 0x10 followed by any word requests a program (`reqOp`=1), with `reqAddr` and `reqData` taken from the second write. `reqAccel` is 1 only for 0x10.
- R6: A first write of 0xB0 requests suspend (`reqOp`=4). A first write of 0xD0 requests resume (`reqOp`=5). Suspend sets status bit 6 when the last program-or-erase request was an erase or blank check. Resume clears bit 6.
- R7: 0x60 followed by 0x01, 0xD0, 0x2F or 0x03 requests lock (6), unlock (7), lock-down (8) or configuration write (11). For the configuration write, `reqData` carries `wrAddr[15:0]` of the second write.
- R8: 0xC0 followed by a word requests a protection-register program (9). If the word is 0xFFFD and the address equals `LOCK_ADDR` (0x80 by default), it requests a protection-register lock (10) instead.
- R9: The status byte is {bit7 = not `wsmBusy`, bit6 = erase suspended, bit5 = erase error, bit4 = program error, bits 3:0 = 0}. It is captured into `statusOut[7:0]` at each `rdStart`, with `statusOut[15:8]` = 0. `statusOut` does not change between captures.
- R10: The first write of every two-write sequence, and also 0xB0 and 0xD0, sets `readMode` to status. The mode stays there until another mode command is written.
- R11: A second write whose code (or block) does not match the pending first write sets status bits 5 and 4. It issues no request and returns the machine to idle.
- R12: A pulse on `wsmPgmErr` sets status bit 4 and a pulse on `wsmErsErr` sets bit 5. Each bit holds until cleared by 0x50.
- R13: A first write with an unrecognised code issues no request and leaves `readMode` unchanged.
- R14: `reqValid` is high for exactly the one clock after the write that completes a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | One-clock host write cycle |
| wrAddr | input | ADDR_W | Write address (word) |
| wrData | input | DATA_W | Write data |
| rdStart | input | 1 | Start of a host read access; captures status |
| wsmBusy | input | 1 | Write state machine busy |
| wsmPgmErr | input | 1 | Program failure pulse |
| wsmErsErr | input | 1 | Erase failure pulse |
| reqValid | output | 1 | Request pulse to the write state machine |
| reqOp | output | 4 | Request operation code |
| reqAccel | output | 1 | Accelerated program variant |
| reqAddr | output | ADDR_W | Request address |
| reqData | output | DATA_W | Request data |
| readMode | output | 2 | Read mode select |
| statusOut | output | DATA_W | Captured status word |

## Verification
The hardest state to reach is the erase-suspended flag next to latched errors. To get there, the stimulus has to issue an erase, suspend it, force an error through a mismatched second write, and then clear the errors. It then reads status to show that bit 6 came through the clear unchanged, and checks that a resume alone removes it. A second difficult case is the read latch. The bench changes `wsmBusy` while no read is starting and shows that `statusOut` keeps its old value until the next `rdStart`.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_IDENT = 8'h90;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_READ_QUERY = 8'h98;
  localparam logic [7:0] CMD_CLEAR_STAT = 8'h50;
  localparam logic [7:0] CMD_ERASE_SET  = 8'h20;
  localparam logic [7:0] CMD_PGM_SET    = 8'h40;
  localparam logic [7:0] CMD_PGM_FAST   = 8'h10;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_BLANK_CONF = 8'hD1;
  localparam logic [7:0] CMD_LOCK_SET   = 8'h60;
  localparam logic [7:0] CMD_LOCK_CONF  = 8'h01;
  localparam logic [7:0] CMD_LDOWN_CONF = 8'h2F;
  localparam logic [7:0] CMD_CFG_CONF   = 8'h03;
  localparam logic [7:0] CMD_PROT_SET   = 8'hC0;
  localparam logic [15:0] PROT_LOCK_WORD = 16'hFFFD;

  typedef enum logic [3:0] {
    OP_NONE      = 4'd0,
    OP_PROGRAM   = 4'd1,
    OP_ERASE     = 4'd2,
    OP_BLANK     = 4'd3,
    OP_SUSPEND   = 4'd4,
    OP_RESUME    = 4'd5,
    OP_LOCK      = 4'd6,
    OP_UNLOCK    = 4'd7,
    OP_LOCKDOWN  = 4'd8,
    OP_PROT_PGM  = 4'd9,
    OP_PROT_LOCK = 4'd10,
    OP_CFG       = 4'd11
  } reqOp_e;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2,
    RM_QUERY  = 2'd3
  } readMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERASE_ARG,
    ST_PGM_ARG,
    ST_LOCK_ARG,
    ST_PROT_ARG
  } cuiState_e;

  typedef struct packed {
    logic      capFirst;
    logic      setMode;
    readMode_e mode;
    logic      issue;
    reqOp_e    op;
    logic      accel;
    logic      dataFromAddr;
    logic      clearErr;
    logic      seqErr;
  } ctlStrobes_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sameBlock,
  output ctlStrobes_t       ctl
);

  cuiState_e state, stateNxt;
  logic      accelQ, accelNxt;
  logic [7:0] cmd;

  assign cmd = wrData[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      accelQ <= 1'b0;
    end else begin
      state  <= stateNxt;
      accelQ <= accelNxt;
    end
  end

  always_comb begin
    stateNxt = state;
    accelNxt = accelQ;
    ctl      = '0;
    if (wrStrobe) begin
      case (state)
        ST_IDLE: begin
          case (cmd)
            CMD_READ_ARRAY: begin ctl.setMode = 1'b1; ctl.mode = RM_ARRAY;  end
            CMD_READ_IDENT: begin ctl.setMode = 1'b1; ctl.mode = RM_IDENT;  end
            CMD_READ_STAT:  begin ctl.setMode = 1'b1; ctl.mode = RM_STATUS; end
            CMD_READ_QUERY: begin ctl.setMode = 1'b1; ctl.mode = RM_QUERY;  end
            CMD_CLEAR_STAT: ctl.clearErr = 1'b1;
            CMD_ERASE_SET: begin
              ctl.capFirst = 1'b1;
              ctl.setMode  = 1'b1;
              ctl.mode     = RM_STATUS;
              stateNxt     = ST_ERASE_ARG;
            end
            CMD_PGM_SET, CMD_PGM_FAST: begin
              ctl.setMode = 1'b1;
              ctl.mode    = RM_STATUS;
              accelNxt    = (cmd == CMD_PGM_FAST);
              stateNxt    = ST_PGM_ARG;
            end
            CMD_LOCK_SET: begin
              ctl.setMode = 1'b1;
              ctl.mode    = RM_STATUS;
              stateNxt    = ST_LOCK_ARG;
            end
            CMD_PROT_SET: begin
              ctl.setMode = 1'b1;
              ctl.mode    = RM_STATUS;
              stateNxt    = ST_PROT_ARG;
            end
            CMD_SUSPEND: begin
              ctl.setMode = 1'b1;
              ctl.mode    = RM_STATUS;
              ctl.issue   = 1'b1;
              ctl.op      = OP_SUSPEND;
            end
            CMD_CONFIRM: begin
              ctl.setMode = 1'b1;
              ctl.mode    = RM_STATUS;
              ctl.issue   = 1'b1;
              ctl.op      = OP_RESUME;
            end
            default: ;
          endcase
        end
        ST_ERASE_ARG: begin
          stateNxt = ST_IDLE;
          if (sameBlock && cmd == CMD_CONFIRM) begin
            ctl.issue = 1'b1;
            ctl.op    = OP_ERASE;
          end else if (sameBlock && cmd == CMD_BLANK_CONF) begin
            ctl.issue = 1'b1;
            ctl.op    = OP_BLANK;
          end else begin
            ctl.seqErr = 1'b1;
          end
        end
        ST_PGM_ARG: begin
          stateNxt  = ST_IDLE;
          ctl.issue = 1'b1;
          ctl.op    = OP_PROGRAM;
          ctl.accel = accelQ;
        end
        ST_LOCK_ARG: begin
          stateNxt = ST_IDLE;
          case (cmd)
            CMD_LOCK_CONF:  begin ctl.issue = 1'b1; ctl.op = OP_LOCK;     end
            CMD_CONFIRM:    begin ctl.issue = 1'b1; ctl.op = OP_UNLOCK;   end
            CMD_LDOWN_CONF: begin ctl.issue = 1'b1; ctl.op = OP_LOCKDOWN; end
            CMD_CFG_CONF: begin
              ctl.issue        = 1'b1;
              ctl.op           = OP_CFG;
              ctl.dataFromAddr = 1'b1;
            end
            default: ctl.seqErr = 1'b1;
          endcase
        end
        ST_PROT_ARG: begin
          stateNxt  = ST_IDLE;
          ctl.issue = 1'b1;
          ctl.op    = (wrData == PROT_LOCK_WORD && wrAddr == LOCK_ADDR)
                      ? OP_PROT_LOCK : OP_PROT_PGM;
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  // Any write that arrives while a second write is pending ends the sequence.
  assert_arg_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && wrStrobe) |=> state == ST_IDLE);

  // An unknown code in idle must not leave idle or raise a request.
  assert_unknown_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && wrStrobe && !ctl.setMode && !ctl.issue && !ctl.clearErr)
      |=> state == ST_IDLE);

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int BLK_LSB = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       ctl,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStart,
  input  logic              wsmBusy,
  input  logic              wsmPgmErr,
  input  logic              wsmErsErr,
  output logic              sameBlock,
  output logic              reqValid,
  output reqOp_e            reqOp,
  output logic              reqAccel,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output readMode_e         readMode,
  output logic [DATA_W-1:0] statusOut
);

  localparam int BLK_W  = ADDR_W - BLK_LSB;
  localparam int HIGH_W = DATA_W - 8;

  logic [BLK_W-1:0] firstBlk;
  logic pgmErr, ersErr, ersSusp, lastErase;
  logic [7:0] statusLive;

  assign sameBlock  = (firstBlk == wrAddr[ADDR_W-1:BLK_LSB]);
  assign statusLive = {~wsmBusy, ersSusp, ersErr, pgmErr, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) firstBlk <= '0;
    else if (ctl.capFirst) firstBlk <= wrAddr[ADDR_W-1:BLK_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) readMode <= RM_ARRAY;
    else if (ctl.setMode) readMode <= ctl.mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqValid <= 1'b0;
      reqOp    <= OP_NONE;
      reqAccel <= 1'b0;
      reqAddr  <= '0;
      reqData  <= '0;
    end else begin
      reqValid <= ctl.issue;
      if (ctl.issue) begin
        reqOp    <= ctl.op;
        reqAccel <= ctl.accel;
        reqAddr  <= wrAddr;
        reqData  <= ctl.dataFromAddr ? wrAddr[DATA_W-1:0] : wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgmErr <= 1'b0;
      ersErr <= 1'b0;
    end else begin
      pgmErr <= (pgmErr & ~ctl.clearErr) | wsmPgmErr | ctl.seqErr;
      ersErr <= (ersErr & ~ctl.clearErr) | wsmErsErr | ctl.seqErr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ersSusp   <= 1'b0;
      lastErase <= 1'b0;
    end else if (ctl.issue) begin
      case (ctl.op)
        OP_ERASE, OP_BLANK: lastErase <= 1'b1;
        OP_PROGRAM:         lastErase <= 1'b0;
        OP_SUSPEND:         if (lastErase) ersSusp <= 1'b1;
        OP_RESUME:          ersSusp <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statusOut <= '0;
    else if (rdStart) statusOut <= {{HIGH_W{1'b0}}, statusLive};
  end

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdStart |=> $stable(statusOut));

  assert_seq_err_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.seqErr |=> (pgmErr && ersErr && !reqValid));

  assert_resume_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.issue && ctl.op == OP_RESUME) |=> !ersSusp);

  assert_req_in_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && (reqOp == OP_PROGRAM || reqOp == OP_ERASE)) |-> readMode == RM_STATUS);

  assert_clear_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.clearErr && !wsmPgmErr && !wsmErsErr) |=> (!pgmErr && !ersErr));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int BLK_LSB = 15,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStart,
  input  logic              wsmBusy,
  input  logic              wsmPgmErr,
  input  logic              wsmErsErr,
  output logic              reqValid,
  output logic [3:0]        reqOp,
  output logic              reqAccel,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqData,
  output logic [1:0]        readMode,
  output logic [DATA_W-1:0] statusOut
);

  ctlStrobes_t ctl;
  logic        sameBlock;
  reqOp_e      reqOpE;
  readMode_e   readModeE;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .wrData(wrData), .sameBlock(sameBlock), .ctl(ctl)
  );

  flash_cmd_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_LSB(BLK_LSB)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrAddr(wrAddr), .wrData(wrData),
    .rdStart(rdStart), .wsmBusy(wsmBusy), .wsmPgmErr(wsmPgmErr),
    .wsmErsErr(wsmErsErr), .sameBlock(sameBlock), .reqValid(reqValid),
    .reqOp(reqOpE), .reqAccel(reqAccel), .reqAddr(reqAddr), .reqData(reqData),
    .readMode(readModeE), .statusOut(statusOut)
  );

  assign reqOp    = reqOpE;
  assign readMode = readModeE;

endmodule

// File: tb/flash_cmd_if_test.sv
`timescale 1ns/1ps
module flash_cmd_if_test;

  localparam int AW = 22;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrStrobe = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic rdStart = 1'b0;
  logic wsmBusy = 1'b0;
  logic wsmPgmErr = 1'b0;
  logic wsmErsErr = 1'b0;
  logic reqValid, reqAccel;
  logic [3:0] reqOp;
  logic [AW-1:0] reqAddr;
  logic [DW-1:0] reqData;
  logic [1:0] readMode;
  logic [DW-1:0] statusOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  flash_cmd_if uut (
    .clk(clk), .rst_n(rst_n), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdStart(rdStart), .wsmBusy(wsmBusy), .wsmPgmErr(wsmPgmErr), .wsmErsErr(wsmErsErr),
    .reqValid(reqValid), .reqOp(reqOp), .reqAccel(reqAccel), .reqAddr(reqAddr),
    .reqData(reqData), .readMode(readMode), .statusOut(statusOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive one write cycle; return at the falling edge after it was taken.
  task automatic writeCmd(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wrStrobe = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrStrobe = 1'b0; wrData = '0;
  endtask

  task automatic readStatus(output logic [DW-1:0] s);
    rdStart = 1'b1;
    @(negedge clk);
    rdStart = 1'b0;
    s = statusOut;
  endtask

  task automatic checkReq(input string req, input int op, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic acc);
    check(req, {31'd0, reqValid}, 32'd1);
    check(req, op, reqOp);
    check(req, reqAddr, a);
    check(req, reqData, d);
    check(req, {31'd0, reqAccel}, {31'd0, acc});
  endtask

  task automatic testReset;
    check("reset R2", readMode, 0);
    check("reset R14", reqValid, 0);
    check("reset R9", statusOut, 0);
  endtask

  task automatic testModes;
    writeCmd(0, 16'h0090); check("R2 ident", readMode, 1);
    writeCmd(0, 16'h0098); check("R2 query", readMode, 3);
    writeCmd(0, 16'h00FF); check("R2 array", readMode, 0);
    writeCmd(0, 16'h0070); check("R2 status", readMode, 2);
    writeCmd(0, 16'hAB90); check("R1 upper byte", readMode, 1);
    writeCmd(0, 16'h3300); check("R13 unknown mode", readMode, 1);
    check("R13 unknown req", reqValid, 0);
  endtask

  task automatic testProgram;
    logic [DW-1:0] s;
    writeCmd(22'h00100, 16'h0040);
    check("R10 setup mode", readMode, 2);
    writeCmd(22'h12345, 16'h1234);
    checkReq("R5 program", 1, 22'h12345, 16'h1234, 1'b0);
    @(negedge clk);
    check("R14 single pulse", reqValid, 0);
    writeCmd(22'h00200, 16'h5510);
    writeCmd(22'h00201, 16'hBEEF);
    checkReq("R5 fast program", 1, 22'h00201, 16'hBEEF, 1'b1);
    wsmBusy = 1'b1;
    readStatus(s); check("R9 busy", s, 16'h0000);
    repeat (3) @(negedge clk);
    check("R10 sticky status", readMode, 2);
    wsmBusy = 1'b0;
    @(negedge clk);
    check("R9 latch hold", statusOut, 16'h0000);
    readStatus(s); check("R9 ready", s, 16'h0080);
    wsmBusy = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 held across busy", statusOut, 16'h0080);
    wsmBusy = 1'b0;
  endtask

  task automatic testErase;
    logic [DW-1:0] s;
    writeCmd(22'h018000, 16'h0020);
    writeCmd(22'h01FFFF, 16'h00D0);
    checkReq("R4 erase", 2, 22'h01FFFF, 16'h00D0, 1'b0);
    writeCmd(22'h018000, 16'h0020);
    writeCmd(22'h018004, 16'h00D1);
    checkReq("R4 blank check", 3, 22'h018004, 16'h00D1, 1'b0);
    writeCmd(22'h018000, 16'h0020);
    writeCmd(22'h020000, 16'h00D0);
    check("R4 other block no req", reqValid, 0);
    readStatus(s); check("R11 block mismatch", s, 16'h00B0);
    writeCmd(0, 16'h00B0);
    checkReq("R6 suspend", 4, 0, 16'h00B0, 1'b0);
    writeCmd(0, 16'h0050);
    check("R3 no req", reqValid, 0);
    check("R3 mode kept", readMode, 2);
    readStatus(s); check("R3 clear keeps suspend", s, 16'h00C0);
    writeCmd(0, 16'h00D0);
    checkReq("R6 resume", 5, 0, 16'h00D0, 1'b0);
    readStatus(s); check("R6 resume clears", s, 16'h0080);
  endtask

  task automatic testLock;
    logic [DW-1:0] s;
    writeCmd(22'h030000, 16'h0060); writeCmd(22'h030000, 16'h0001);
    checkReq("R7 lock", 6, 22'h030000, 16'h0001, 1'b0);
    writeCmd(22'h030000, 16'h0060); writeCmd(22'h030000, 16'h00D0);
    checkReq("R7 unlock", 7, 22'h030000, 16'h00D0, 1'b0);
    writeCmd(22'h030000, 16'h0060); writeCmd(22'h030000, 16'h002F);
    checkReq("R7 lockdown", 8, 22'h030000, 16'h002F, 1'b0);
    writeCmd(22'h001234, 16'h0060); writeCmd(22'h001234, 16'h0003);
    checkReq("R7 config", 11, 22'h001234, 16'h1234, 1'b0);
    writeCmd(22'h030000, 16'h0060); writeCmd(22'h030000, 16'h0077);
    check("R11 bad lock no req", reqValid, 0);
    readStatus(s); check("R11 bad lock flags", s, 16'h00B0);
    writeCmd(0, 16'h00FF);
    check("R11 back to idle", readMode, 0);
    writeCmd(0, 16'h0050);
  endtask

  task automatic testProt;
    writeCmd(22'h000081, 16'h00C0); writeCmd(22'h000081, 16'hABCD);
    checkReq("R8 prot program", 9, 22'h000081, 16'hABCD, 1'b0);
    writeCmd(22'h000081, 16'h00C0); writeCmd(22'h000081, 16'hFFFD);
    checkReq("R8 other addr", 9, 22'h000081, 16'hFFFD, 1'b0);
    writeCmd(22'h000080, 16'h00C0); writeCmd(22'h000080, 16'hFFFD);
    checkReq("R8 prot lock", 10, 22'h000080, 16'hFFFD, 1'b0);
  endtask

  task automatic testWsmErr;
    logic [DW-1:0] s;
    wsmPgmErr = 1'b1; @(negedge clk); wsmPgmErr = 1'b0;
    repeat (2) @(negedge clk);
    readStatus(s); check("R12 program error", s, 16'h0090);
    wsmErsErr = 1'b1; @(negedge clk); wsmErsErr = 1'b0;
    readStatus(s); check("R12 erase error", s, 16'h00B0);
    writeCmd(0, 16'h0050);
    readStatus(s); check("R12 cleared", s, 16'h0080);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testModes();
    testProgram();
    testErase();
    testLock();
    testProt();
    testWsmErr();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule